// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block sits between the power-enable controls of a stereo capture path and a stereo playback path and the sample datapaths of those converters. When a path is switched on while the other path is fully off, the block runs a fixed initialization interval for that path. The interval is measured in sample periods, each marked by a one-cycle frame-rate strobe. While it runs, the path's busy flag is high and both channels of that path's sample data are replaced by two's-complement zero. When the interval ends, or the path is switched off, the data is released and passes through unchanged.

The capture path has independent left and right enables. The playback path has a single enable. When a path is switched on while the other path is already powered, no initialization interval is run and the data passes through at once. All state clears on a synchronous, active-low reset. Every output is registered, so data moves from input to output with one clock of latency.

Top module: `conv_init_seq`

## Requirements
- R1: While `pwr_rst_n` is 0 at a clock edge, both busy flags and all four data outputs are 0 after that edge.
- R2: When `cap_en_l` or `cap_en_r` is seen going from 0 to 1 at a clock edge while `play_en` is 1'b0 and capture is not already initializing, `cap_busy` is 1 after that edge.
- R3: When `play_en` is seen going from 0 to 1 at a clock edge while `cap_en_l` and `cap_en_r` are both 0, `play_busy` is 1 after that edge.
- R4: An enable rising while the other path has any enable at 1 starts no initialization, and the two busy flags are never 1 together.
- R5: Once busy, a path counts only clock edges where `smp_stb` is 1. Its busy flag stays 1 through the first INIT_PERIODS-1 such edges and is 0 after the edge carrying the INIT_PERIODS-th strobe (default 1059).
- R6: Whenever `cap_busy` is 1, `cap_dout_l` and `cap_dout_r` are both 0.
- R7: Whenever `play_busy` is 1, `play_dout_l` and `play_dout_r` are both 0.
- R8: At a clock edge after which a path's busy flag is 0, each data output of that path takes the value its input had at that edge.
- R9: If a path's enable is 0 at a clock edge (for capture, both `cap_en_l` and `cap_en_r` 0), that path's busy flag is 0 after the edge.
- R10: A capture enable rising while `cap_busy` is 1 does not restart the count: busy still clears after INIT_PERIODS strobes in total from the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Synchronous active-low reset / power-down |
| smp_stb | input | 1 | One-cycle strobe per sample period |
| cap_en_l | input | 1 | Capture left converter power enable |
| cap_en_r | input | 1 | Capture right converter power enable |
| play_en | input | 1 | Playback converter power enable |
| cap_din_l | input | SMP_W | Capture left sample from converter |
| cap_din_r | input | SMP_W | Capture right sample from converter |
| play_din_l | input | SMP_W | Playback left sample from serial interface |
| play_din_r | input | SMP_W | Playback right sample from serial interface |
| cap_busy | output | 1 | Capture initialization in progress |
| play_busy | output | 1 | Playback initialization in progress |
| cap_dout_l | output | SMP_W | Capture left sample, gated |
| cap_dout_r | output | SMP_W | Capture right sample, gated |
| play_dout_l | output | SMP_W | Playback left sample to converter, gated |
| play_dout_r | output | SMP_W | Playback right sample to converter, gated |

## Verification
On every cycle, the assertions check the following: zeroed data while a path is busy, the two flags never high together, abort on a dropped enable, a busy flag rising only after a trigger, and the counter moving only on strobes without restarting. Which enable combinations start an interval cannot be seen from a single cycle, so the bench sweeps every prior enable state against every single-enable rise. The exact strobe count before busy clears, the count carrying on across a second capture enable rise, and the one-cycle pass-through latency are also bench-only, shown by counting strobes in scenarios.

// File: rtl/cvinit_pkg.sv
package cvinit_pkg;
  localparam int DEF_SMP_W = 16;
  localparam int DEF_INIT_PERIODS = 1059;

  typedef enum logic {
    T_IDLE = 1'b0,
    T_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/cvinit_trig.sv
module cvinit_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en_l,
  input  logic cap_en_r,
  input  logic play_en,
  output logic cap_trig,
  output logic play_trig
);
  logic prev_l, prev_r, prev_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_l <= 1'b0;
      prev_r <= 1'b0;
      prev_p <= 1'b0;
    end else begin
      prev_l <= cap_en_l;
      prev_r <= cap_en_r;
      prev_p <= play_en;
    end
  end

  logic rise_l, rise_r, rise_p;
  always_comb begin
    rise_l    = cap_en_l & ~prev_l;
    rise_r    = cap_en_r & ~prev_r;
    rise_p    = play_en & ~prev_p;
    cap_trig  = (rise_l | rise_r) & ~play_en;
    play_trig = rise_p & ~cap_en_l & ~cap_en_r;
  end

  // R4: the two triggers exclude each other
  assert_trig_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_trig && play_trig));
endmodule

// File: rtl/cvinit_timer.sv
module cvinit_timer
  import cvinit_pkg::*;
#(
  parameter int INIT_PERIODS = DEF_INIT_PERIODS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic en,
  input  logic trig,
  output logic busy,
  output logic busy_nxt
);
  localparam int CNT_W = (INIT_PERIODS > 2) ? $clog2(INIT_PERIODS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_PERIODS - 1);

  tmr_state_e st, st_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    if (!en) begin
      st_nxt  = T_IDLE;
      cnt_nxt = '0;
    end else if (st == T_IDLE) begin
      if (trig) begin
        st_nxt  = T_RUN;
        cnt_nxt = '0;
      end
    end else if (stb) begin
      if (cnt == LAST) begin
        st_nxt  = T_IDLE;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= T_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  assign busy     = (st == T_RUN);
  assign busy_nxt = (st_nxt == T_RUN);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));

  assert_hold_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && !stb) |=> (busy && $stable(cnt)));

  // R10: while running, each strobe only advances the count by one
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && stb && (cnt != LAST)) |=> (busy && (cnt == $past(cnt) + 1'b1)));

  // R2 / R3: a busy flag rises only after a trigger
  assert_start_on_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig));
endmodule

// File: rtl/cvinit_gate.sv
module cvinit_gate #(
  parameter int W  = 16,
  parameter int CH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 force_zero,
  input  logic [CH-1:0][W-1:0] din,
  output logic [CH-1:0][W-1:0] dout
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)          dout[c] <= '0;
      else if (force_zero) dout[c] <= '0;
      else                 dout[c] <= din[c];
    end
  end
endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
  import cvinit_pkg::*;
#(
  parameter int SMP_W        = DEF_SMP_W,
  parameter int INIT_PERIODS = DEF_INIT_PERIODS
) (
  input  logic             clk,
  input  logic             pwr_rst_n,
  input  logic             smp_stb,
  input  logic             cap_en_l,
  input  logic             cap_en_r,
  input  logic             play_en,
  input  logic [SMP_W-1:0] cap_din_l,
  input  logic [SMP_W-1:0] cap_din_r,
  input  logic [SMP_W-1:0] play_din_l,
  input  logic [SMP_W-1:0] play_din_r,
  output logic             cap_busy,
  output logic             play_busy,
  output logic [SMP_W-1:0] cap_dout_l,
  output logic [SMP_W-1:0] cap_dout_r,
  output logic [SMP_W-1:0] play_dout_l,
  output logic [SMP_W-1:0] play_dout_r
);
  localparam int NCH = 2;

  logic cap_trig, play_trig;
  logic cap_any;
  logic cap_busy_nxt, play_busy_nxt;

  assign cap_any = cap_en_l | cap_en_r;

  cvinit_trig trig_i (
    .clk       (clk),
    .rst_n     (pwr_rst_n),
    .cap_en_l  (cap_en_l),
    .cap_en_r  (cap_en_r),
    .play_en   (play_en),
    .cap_trig  (cap_trig),
    .play_trig (play_trig)
  );

  cvinit_timer #(.INIT_PERIODS(INIT_PERIODS)) cap_tmr_i (
    .clk      (clk),
    .rst_n    (pwr_rst_n),
    .stb      (smp_stb),
    .en       (cap_any),
    .trig     (cap_trig),
    .busy     (cap_busy),
    .busy_nxt (cap_busy_nxt)
  );

  cvinit_timer #(.INIT_PERIODS(INIT_PERIODS)) play_tmr_i (
    .clk      (clk),
    .rst_n    (pwr_rst_n),
    .stb      (smp_stb),
    .en       (play_en),
    .trig     (play_trig),
    .busy     (play_busy),
    .busy_nxt (play_busy_nxt)
  );

  logic [NCH-1:0][SMP_W-1:0] cap_in, cap_out, play_in, play_out;
  assign cap_in  = {cap_din_r, cap_din_l};
  assign play_in = {play_din_r, play_din_l};

  cvinit_gate #(.W(SMP_W), .CH(NCH)) cap_gate_i (
    .clk        (clk),
    .rst_n      (pwr_rst_n),
    .force_zero (cap_busy_nxt),
    .din        (cap_in),
    .dout       (cap_out)
  );

  cvinit_gate #(.W(SMP_W), .CH(NCH)) play_gate_i (
    .clk        (clk),
    .rst_n      (pwr_rst_n),
    .force_zero (play_busy_nxt),
    .din        (play_in),
    .dout       (play_out)
  );

  assign cap_dout_l  = cap_out[0];
  assign cap_dout_r  = cap_out[1];
  assign play_dout_l = play_out[0];
  assign play_dout_r = play_out[1];

  assert_cap_zero_R6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    cap_busy |-> (cap_dout_l == '0 && cap_dout_r == '0));

  assert_play_zero_R7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    play_busy |-> (play_dout_l == '0 && play_dout_r == '0));

  assert_one_path_R4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !(cap_busy && play_busy));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !pwr_rst_n |=> (!cap_busy && !play_busy && cap_dout_l == '0 && play_dout_r == '0));
endmodule

// File: tb/conv_init_seq_tb_top.sv
`timescale 1ns/1ps
module conv_init_seq_tb_top;
  localparam int W = 16;
  localparam int N = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, stb, en_l, en_r, en_p;
  logic [W-1:0] cdl, cdr, pdl, pdr;
  logic cbusy, pbusy;
  logic [W-1:0] col, cor, pol, por;

  conv_init_seq #(.SMP_W(W), .INIT_PERIODS(N)) dut_i (
    .clk(clk), .pwr_rst_n(rst_n), .smp_stb(stb),
    .cap_en_l(en_l), .cap_en_r(en_r), .play_en(en_p),
    .cap_din_l(cdl), .cap_din_r(cdr), .play_din_l(pdl), .play_din_r(pdr),
    .cap_busy(cbusy), .play_busy(pbusy),
    .cap_dout_l(col), .cap_dout_r(cor), .play_dout_l(pol), .play_dout_r(por)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s);
    stb = s;
    @(posedge clk);
    #1;
    stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en_l = 0; en_r = 0; en_p = 0;
    cyc(0); cyc(0);
    rst_n = 1'b1;
    cyc(0);
  endtask

  task automatic chk_cap(input string tag, input logic exp_busy);
    check({tag, " cap_busy"}, cbusy, exp_busy);
    check({tag, " cap_l"}, col, exp_busy ? 16'h0 : cdl);
    check({tag, " cap_r"}, cor, exp_busy ? 16'h0 : cdr);
  endtask

  task automatic chk_play(input string tag, input logic exp_busy);
    check({tag, " play_busy"}, pbusy, exp_busy);
    check({tag, " play_l"}, pol, exp_busy ? 16'h0 : pdl);
    check({tag, " play_r"}, por, exp_busy ? 16'h0 : pdr);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    stb = 0; rst_n = 0; en_l = 0; en_r = 0; en_p = 0;
    cdl = 16'h1234; cdr = 16'hA5A5; pdl = 16'h8001; pdr = 16'h7FFE;

    // R1: reset clears flags and data
    en_l = 1; en_p = 0;
    cyc(0); cyc(1);
    check("R1 cap_busy", cbusy, 0);
    check("R1 play_busy", pbusy, 0);
    check("R1 cap_l", col, 0);
    check("R1 play_r", por, 0);

    // R2 R3 R4 R8: sweep every prior enable state against each single rise
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 3; b++) begin
        logic [2:0] sv;
        logic exp_c, exp_p;
        sv = 3'(s);
        if (sv[b]) continue;
        do_reset();
        en_l = sv[0]; en_r = sv[1]; en_p = sv[2];
        repeat (N + 3) cyc(1);
        cdl = 16'(16'h1000 + s * 16 + b); cdr = ~cdl;
        pdl = 16'(16'h2000 + s * 16 + b); pdr = ~pdl;
        cyc(0);
        chk_cap("R8 settled", 0);
        chk_play("R8 settled", 0);
        if (b == 0) en_l = 1;
        if (b == 1) en_r = 1;
        if (b == 2) en_p = 1;
        cyc(0);
        exp_c = (b < 2) && !sv[2];
        exp_p = (b == 2) && (sv[1:0] == 2'b00);
        chk_cap(exp_c ? "R2 trig" : "R4 no cap init", exp_c);
        chk_play(exp_p ? "R3 trig" : "R4 no play init", exp_p);
      end
    end

    // R5 R6: exact strobe count, no-strobe hold
    do_reset();
    cdl = 16'h0F0F; cdr = 16'hF00F;
    en_l = 1;
    cyc(0);
    chk_cap("R6 start", 1);
    for (int k = 0; k < N; k++) begin
      repeat (2) cyc(0);
      check("R5 hold no strobe", cbusy, 1);
      cyc(1);
      chk_cap(k < N - 1 ? "R5 during" : "R5 end", k < N - 1);
    end

    // R7 R5: playback interval
    do_reset();
    pdl = 16'h4321; pdr = 16'hC0DE;
    en_p = 1;
    cyc(0);
    chk_play("R7 start", 1);
    repeat (N - 1) cyc(1);
    chk_play("R7 before last", 1);
    cyc(1);
    chk_play("R5 play end", 0);

    // R9: abort on enable drop (capture, then playback)
    do_reset();
    en_r = 1;
    cyc(0); cyc(1); cyc(1);
    check("R9 pre", cbusy, 1);
    en_r = 0;
    cyc(0);
    chk_cap("R9 cap abort", 0);
    do_reset();
    en_p = 1;
    cyc(0); cyc(1);
    en_p = 0;
    cyc(0);
    chk_play("R9 play abort", 0);

    // R10: second capture enable during init does not restart
    do_reset();
    en_l = 1;
    cyc(0);
    repeat (3) cyc(1);
    en_r = 1;
    cyc(0);
    check("R10 still busy", cbusy, 1);
    repeat (N - 4) cyc(1);
    check("R10 before last", cbusy, 1);
    cyc(1);
    chk_cap("R10 ends on original count", 0);

    // R8: pass-through follows input with one cycle latency
    cdl = 16'h5555;
    cyc(0);
    check("R8 latency", col, 16'h5555);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule